// File: doc/BRIEF.md
# Timestamp Record Queue with Word-Serial Readout

This block holds the hardware timestamps of precision-time event messages seen in one direction of one network port, until the host collects them. Capture logic next to the MAC presents a whole record in one cycle with a strobe. A record holds a message tag, 48-bit seconds, 32-bit nanoseconds, a 64-bit source clock identity, a source port number and a sequence number. The block queues the record if timestamping is enabled and there is room. If the queue is full, it drops the record and counts the loss.

The host reads a record through one 16-bit data port. Each read returns one word, so a record takes twelve reads. A read-position counter is visible in the status word. The host uses it to confirm it is at a record boundary before it starts a read sequence. A not-empty flag is exported so that a shared buffer-status register can gather the flags of several queues. A write to the status word sets the enable bit and clears the loss counter.

Top module: `ts_word_fifo`

## Requirements
- R1: After reset the queue is empty, `nempty_o` is 0 and `stat_o` reads 0 (enable off, position 0, loss count 0).
- R2: `stat_o` carries the enable bit in bit 15, the read position in bits 12:8 and the loss count in bits 7:4. All other bits read 0. A cycle with `stat_wr_i` high loads the enable bit from `stat_en_wdata_i`.
- R3: A capture strobe while the enable bit is 0 stores nothing and leaves the loss count unchanged.
- R4: While the queue holds a record, `data_o` shows word P of the oldest record, where P is the read position. The word order is fixed, and each field is given most significant word first. Word 0 is the tag. Words 1 to 3 are the seconds. Words 4 and 5 are the nanoseconds. Words 6 to 9 are the clock identity. Word 10 is the port number. Word 11 is the sequence number. The tag is returned unchanged, so its bits 2:0 still hold the message code (1, 2, 3 or 4).
- R5: Each read while the queue is not empty advances the position by one. A read at position 11 removes the record and returns the position to 0.
- R6: While the queue is empty, `data_o` is 0, a read leaves the position at 0, and the read changes nothing.
- R7: Records come out in capture order, and up to DEPTH records are held.
- R8: An enabled capture arriving while DEPTH records are held, with no removal in the same cycle, is dropped. It raises the loss count by one, and the count saturates at 15.
- R9: A status write clears the loss count. The clear wins over a drop in the same cycle.
- R10: An enabled capture in the same cycle as a record removal is stored, even when the queue is full, and the record count stays the same.
- R11: `nempty_o` is 1 exactly when at least one record is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_stb_i | input | 1 | Capture strobe, one record per high cycle |
| cap_tag_i | input | 16 | Tag word, message code in bits 2:0 |
| cap_sec_i | input | 48 | Seconds |
| cap_nsec_i | input | 32 | Nanoseconds |
| cap_clkid_i | input | 64 | Source clock identity |
| cap_port_i | input | 16 | Source port number |
| cap_seq_i | input | 16 | Sequence number |
| data_rd_i | input | 1 | Data-port read strobe |
| data_o | output | 16 | Current record word |
| stat_wr_i | input | 1 | Status write strobe |
| stat_en_wdata_i | input | 1 | Enable value written (bit 15 of the status word) |
| stat_o | output | 16 | Status word |
| nempty_o | output | 1 | Queue holds at least one record |

## Verification
The bench builds the block with DEPTH set to 5. At that depth the full-queue cases are reached in a few dozen cycles: drops, saturation of the loss counter at 15, and a capture landing in the same cycle as a removal. The default depth of 90 would need long fill phases to reach them. Random mixes of captures, reads and status writes then exercise pointer wrap-around several times, since they cross the depth boundary repeatedly.

// File: rtl/ts_fifo_pkg.sv
package ts_fifo_pkg;
  localparam int WORD_W   = 16;
  localparam int REC_WRDS = 12;
  localparam int POS_W    = 5;
  localparam int LOSS_W   = 4;

  // Field order is the readout order: first field sits at the top bits.
  typedef struct packed {
    logic [15:0] tag;
    logic [47:0] sec;
    logic [31:0] nsec;
    logic [63:0] clkid;
    logic [15:0] portnum;
    logic [15:0] seqid;
  } ts_rec_t;

  localparam int REC_W = $bits(ts_rec_t);
endpackage

// File: rtl/ts_fifo_store.sv
module ts_fifo_store
  import ts_fifo_pkg::*;
#(
  parameter int DEPTH = 90
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic                          pop_i,
  input  ts_rec_t                       din_i,
  output ts_rec_t                       head_o,
  output logic [$clog2(DEPTH+1)-1:0]    count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);

  ts_rec_t           mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_i) begin
      wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_i) begin
      rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage array carries no reset; its content is qualified by cnt_q.
  always_ff @(posedge clk_i) begin
    if (push_i) begin
      mem_q[wr_ptr_q] <= din_i;
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/ts_word_pick.sv
module ts_word_pick
  import ts_fifo_pkg::*;
(
  input  ts_rec_t                 rec_i,
  input  logic [POS_W-1:0]        pos_i,
  input  logic                    valid_i,
  output logic [WORD_W-1:0]       word_o
);
  logic [WORD_W-1:0] words [REC_WRDS];
  logic [REC_W-1:0]  flat;

  assign flat = rec_i;

  for (genvar w = 0; w < REC_WRDS; w++) begin : g_word
    assign words[w] = flat[REC_W-1-w*WORD_W -: WORD_W];
  end

  always_comb begin
    word_o = '0;
    if (valid_i) begin
      for (int w = 0; w < REC_WRDS; w++) begin
        if (pos_i == POS_W'(w)) begin
          word_o = words[w];
        end
      end
    end
  end
endmodule

// File: rtl/ts_read_ctrl.sv
module ts_read_ctrl
  import ts_fifo_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               nempty_i,
  output logic [POS_W-1:0]   pos_o,
  output logic               pop_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(REC_WRDS-1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             step;

  assign step  = rd_i && nempty_i;
  assign pop_o = step && (pos_q == LAST_POS);

  always_comb begin
    pos_d = pos_q;
    if (step) begin
      pos_d = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_d;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/ts_stat_reg.sv
module ts_stat_reg
  import ts_fifo_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               en_wdata_i,
  input  logic               drop_i,
  output logic               en_o,
  output logic [LOSS_W-1:0]  loss_o
);
  localparam logic [LOSS_W-1:0] LOSS_MAX = '1;

  logic              en_q, en_d;
  logic [LOSS_W-1:0] loss_q, loss_d;

  always_comb begin
    en_d   = en_q;
    loss_d = loss_q;
    if (wr_i) begin
      en_d   = en_wdata_i;
      loss_d = '0;
    end else if (drop_i && (loss_q != LOSS_MAX)) begin
      loss_d = loss_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      loss_q <= '0;
    end else begin
      en_q   <= en_d;
      loss_q <= loss_d;
    end
  end

  assign en_o   = en_q;
  assign loss_o = loss_q;
endmodule

// File: rtl/ts_word_fifo.sv
module ts_word_fifo
  import ts_fifo_pkg::*;
#(
  parameter int DEPTH = 90
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_stb_i,
  input  logic [15:0]  cap_tag_i,
  input  logic [47:0]  cap_sec_i,
  input  logic [31:0]  cap_nsec_i,
  input  logic [63:0]  cap_clkid_i,
  input  logic [15:0]  cap_port_i,
  input  logic [15:0]  cap_seq_i,
  input  logic         data_rd_i,
  output logic [15:0]  data_o,
  input  logic         stat_wr_i,
  input  logic         stat_en_wdata_i,
  output logic [15:0]  stat_o,
  output logic         nempty_o
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  ts_rec_t            cap_rec, head_rec;
  logic [CNT_W-1:0]   count;
  logic [POS_W-1:0]   pos;
  logic [LOSS_W-1:0]  loss;
  logic               en, full, nempty, pop, take, push, drop;

  assign cap_rec = '{tag: cap_tag_i, sec: cap_sec_i, nsec: cap_nsec_i,
                     clkid: cap_clkid_i, portnum: cap_port_i,
                     seqid: cap_seq_i};

  assign nempty = (count != '0);
  assign full   = (count == FULL_CNT);
  assign take   = cap_stb_i && en;
  assign push   = take && (!full || pop);
  assign drop   = take && full && !pop;

  ts_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_s2_q),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (cap_rec),
    .head_o  (head_rec),
    .count_o (count)
  );

  ts_read_ctrl u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_s2_q),
    .rd_i     (data_rd_i),
    .nempty_i (nempty),
    .pos_o    (pos),
    .pop_o    (pop)
  );

  ts_word_pick u_pick (
    .rec_i   (head_rec),
    .pos_i   (pos),
    .valid_i (nempty),
    .word_o  (data_o)
  );

  ts_stat_reg u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_s2_q),
    .wr_i       (stat_wr_i),
    .en_wdata_i (stat_en_wdata_i),
    .drop_i     (drop),
    .en_o       (en),
    .loss_o     (loss)
  );

  assign stat_o   = {en, 2'b00, pos, loss, 4'b0000};
  assign nempty_o = nempty;
endmodule

// File: rtl/ts_word_fifo_chk.sv
module ts_word_fifo_chk #(
  parameter int DEPTH = 90
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cap_stb_i,
  input logic         data_rd_i,
  input logic [15:0]  data_o,
  input logic         stat_wr_i,
  input logic [15:0]  stat_o
  ,input logic        nempty_o
);
  // R5: position never leaves the twelve-word window
  a_r5_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[12:8] <= 5'd11);

  // R5: an in-record read advances the position by one
  a_r5_pos_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && nempty_o && stat_o[12:8] < 5'd11)
      |=> stat_o[12:8] == $past(stat_o[12:8]) + 5'd1);

  // R6: empty queue shows zero data and zero position
  a_r6_empty_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nempty_o |-> (data_o == 16'h0 && stat_o[12:8] == 5'd0));

  // R8: saturated loss count stays saturated until a status write
  a_r8_loss_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[7:4] == 4'hF && !stat_wr_i) |=> stat_o[7:4] == 4'hF);

  // R9: status write clears the loss count
  a_r9_loss_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i |=> stat_o[7:4] == 4'h0);

  // R3: with enable clear, an empty queue stays empty
  a_r3_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_o[15] && !stat_wr_i && !nempty_o) |=> !nempty_o);

  // R2: reserved status bits read zero
  a_r2_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[14:13] == 2'b00 && stat_o[3:0] == 4'h0));

  // R3: loss count is untouched by captures while disabled
  a_r3_no_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_o[15] && !stat_wr_i && cap_stb_i) |=> $stable(stat_o[7:4]));
endmodule

bind ts_word_fifo ts_word_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cap_stb_i (cap_stb_i),
  .data_rd_i (data_rd_i),
  .data_o    (data_o),
  .stat_wr_i (stat_wr_i),
  .stat_o    (stat_o),
  .nempty_o  (nempty_o)
);

// File: tb/tb_ts_word_fifo.sv
module tb_ts_word_fifo;
  localparam int DEPTH = 5;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         cap_stb_i;
  logic [15:0]  cap_tag_i;
  logic [47:0]  cap_sec_i;
  logic [31:0]  cap_nsec_i;
  logic [63:0]  cap_clkid_i;
  logic [15:0]  cap_port_i;
  logic [15:0]  cap_seq_i;
  logic         data_rd_i;
  logic [15:0]  data_o;
  logic         stat_wr_i;
  logic         stat_en_wdata_i;
  logic [15:0]  stat_o;
  logic         nempty_o;

  always #2 clk_i = ~clk_i;

  ts_word_fifo #(.DEPTH(DEPTH)) dut (
    .clk_i, .rst_ni, .cap_stb_i, .cap_tag_i, .cap_sec_i, .cap_nsec_i,
    .cap_clkid_i, .cap_port_i, .cap_seq_i, .data_rd_i, .data_o,
    .stat_wr_i, .stat_en_wdata_i, .stat_o, .nempty_o
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [191:0] mq [$];
  int           m_pos;
  bit           m_en;
  int           m_loss;
  logic [191:0] next_rec;

  function automatic logic [15:0] word_of(logic [191:0] r, int i);
    return r[191-16*i -: 16];
  endfunction

  function automatic logic [15:0] exp_stat();
    return {m_en, 2'b00, 5'(m_pos), 4'(m_loss), 4'h0};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [191:0] mk_rec(logic [2:0] code);
    logic [191:0] r;
    r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    r[178:176] = code;
    return r;
  endfunction

  task automatic step(string req, bit cap, bit rd, bit wr, bit wen, logic [191:0] rec);
    bit popping, pushable;
    @(negedge clk_i);
    cap_stb_i = cap; data_rd_i = rd; stat_wr_i = wr; stat_en_wdata_i = wen;
    {cap_tag_i, cap_sec_i, cap_nsec_i, cap_clkid_i, cap_port_i, cap_seq_i} = rec;
    #1;
    check(req, "status", 64'(stat_o), 64'(exp_stat()));
    check(req, "nempty", 64'(nempty_o), 64'(mq.size() > 0));
    check(req, "data", 64'(data_o),
          64'((mq.size() > 0) ? word_of(mq[0], m_pos) : 16'h0));
    @(posedge clk_i);
    popping  = rd && (mq.size() > 0) && (m_pos == 11);
    pushable = cap && m_en && ((mq.size() < DEPTH) || popping);
    if (rd && mq.size() > 0) begin
      if (m_pos == 11) begin
        m_pos = 0;
        void'(mq.pop_front());
      end else begin
        m_pos++;
      end
    end
    if (pushable) mq.push_back(rec);
    else if (cap && m_en && m_loss < 15) m_loss++;
    if (wr) begin
      m_loss = 0;
      m_en = wen;
    end
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_pos = 0; m_en = 0; m_loss = 0;
    rst_ni = 1'b0;
    cap_stb_i = 0; data_rd_i = 0; stat_wr_i = 0; stat_en_wdata_i = 0;
    {cap_tag_i, cap_sec_i, cap_nsec_i, cap_clkid_i, cap_port_i, cap_seq_i} = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    idle("R1");
    // R3: capture while disabled
    step("R3", 1, 0, 0, 0, mk_rec(3'd1));
    idle("R3");
    // R6: read while empty
    step("R6", 0, 1, 0, 0, '0);
    idle("R6");
    // R2: enable
    step("R2", 0, 0, 1, 1, '0);
    idle("R2");
    // R4/R5: two records, read word by word
    step("R4", 1, 0, 0, 0, mk_rec(3'd1));
    step("R4", 1, 0, 0, 0, mk_rec(3'd3));
    for (int i = 0; i < 24; i++) step("R5", 0, 1, 0, 0, '0);
    idle("R11");
    // R7/R8: overfill to saturate losses
    for (int i = 0; i < DEPTH + 18; i++) step("R8", 1, 0, 0, 0, mk_rec(3'(i % 4 + 1)));
    idle("R8");
    // R10: capture with removal while full
    for (int i = 0; i < 11; i++) step("R7", 0, 1, 0, 0, '0);
    step("R10", 1, 1, 0, 0, mk_rec(3'd2));
    idle("R10");
    // R9: clear with a simultaneous drop
    step("R9", 1, 0, 1, 1, mk_rec(3'd4));
    idle("R9");
    // drain in order
    for (int i = 0; i < 12 * DEPTH; i++) step("R7", 0, 1, 0, 0, '0);
    step("R6", 0, 1, 0, 0, '0);
    idle("R6");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit c, r, w;
      c = ($urandom % 3) == 0;
      r = ($urandom % 4) != 0;
      w = ($urandom % 60) == 0;
      step("R7", c, r, w, ($urandom % 8) != 0, mk_rec(3'($urandom % 4 + 1)));
    end
    idle("R7");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule